// File: doc/BRIEF.md
# Serial Flash Word Read Port

This block gives a small processor read-only access to the contents of a serial configuration flash, seen as an array of 32-bit words. The processor pulses a read request together with an 18-bit word index. The block raises its busy flag, runs one serial transaction on the flash pins, and drops busy once the fetched word is on its data output. The word stays there until the next read completes.

A build-time parameter picks one of four read formats: plain single-line read, single-line read with a dummy gap (for a faster serial clock), read with a two-line data phase, and read with two-line address, gap and data phases. The serial clock runs at half the system clock. Each data bit is set up while the serial clock is low and stays stable across its rising edge. The two data lines reach the pads as separate output, output-enable and input vectors, so the pad ring can build bidirectional buffers.

A flash may be left in deep power-down, where it obeys only one command. After reset, the block therefore first sends the release command. It then keeps chip select high for a set recovery time before it accepts any read.

Top module: `sflash_rd_port`

## Requirements
- R1: After reset, busy is high and the first serial frame is exactly 8 clocks long and carries opcode 0xAB on IO0, MSB first. No read is served before this frame.
- R2: After the release frame, chip select is high and busy stays high for exactly RECOV_CYC system clocks, then busy drops.
- R3: Each read frame starts with the mode's opcode, MSB first: 0x03 (MODE 0, standard), 0x0B (MODE 1, fast), 0x3B (MODE 2, dual output), 0xBB (MODE 3, dual I/O). The opcode is always sent on IO0 alone.
- R4: The 24-bit address sent after the opcode is four zero bits, then the word index, then two zero bits, MSB first. In MODE 3 it is sent two bits per clock, with IO1 carrying the higher bit.
- R5: A read frame lasts 64, 72, 56 or 44 serial clocks for modes 0 to 3. Busy stays high for twice that number of system clocks, counted from the clock after the request.
- R6: IO1 is never driven in modes 0 to 2. IO0 stops driving after the gap in modes 2 and 3. Both lines are driven during the address and gap clocks of mode 3. In modes 0 and 1, IO0 stays driven for the whole frame.
- R7: Data comes in on IO1 in modes 0 and 1, and on IO1 (higher bit) and IO0 (lower bit) in modes 2 and 3. The first byte received lands in output bits 7:0, the fourth in bits 31:24, each byte MSB first.
- R8: The serial clock is low whenever chip select is high. The data lines and their enables never change across a rising serial clock edge.
- R9: Busy is high whenever chip select is low.
- R10: A read request that arrives while busy is high starts no frame and does not change the word that is returned.
- R11: The output word changes only when a read completes. Between reads it holds its value, whatever the address and request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | One-cycle read request |
| rd_word_addr | input | 18 | Word index, sampled with the request |
| rd_data | output | 32 | Last word fetched |
| rd_busy | output | 1 | High while a frame or the recovery wait is in progress |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io_o | output | 2 | Values driven on IO1/IO0 |
| io_oe | output | 2 | Output enables for IO1/IO0 |
| io_i | input | 2 | Values read from IO1/IO0 |

## Verification
The assertions assume that requests come from a synchronous master, aligned to the system clock, and that io_i changes only after a falling serial clock edge, as a flash does. The bench's flash model changes its lines only on the falling serial clock, which happens right after a system clock edge, so io_i is settled a full system clock before the block samples it. The request and address are driven at falling system clock edges, including the deliberate requests sent during the release frame and in the middle of a read.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_DOUT = 2'd2,
    MODE_DIO  = 2'd3
  } sfl_mode_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_WAKE, ST_RECOV, ST_IDLE, ST_SEND, ST_RECV
  } sfl_state_e;

  localparam int CNT_W   = 6;
  localparam int FRAME_W = 40;
  localparam int WORD_W  = 32;
  localparam int WADDR_W = 18;
  localparam logic [7:0]       OP_RELEASE = 8'hAB;
  localparam logic [CNT_W-1:0] CMD_CLKS   = 6'd8;

  function automatic logic [7:0] op_of(sfl_mode_e m);
    case (m)
      MODE_STD:  return 8'h03;
      MODE_FAST: return 8'h0B;
      MODE_DOUT: return 8'h3B;
      default:   return 8'hBB;
    endcase
  endfunction

  // serial clocks spent before data arrives (command, address, gap)
  function automatic logic [CNT_W-1:0] send_clks(sfl_mode_e m);
    case (m)
      MODE_STD: return 6'd32;
      MODE_DIO: return CMD_CLKS + 6'd12 + 6'd8;
      default:  return 6'd40;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] recv_clks(sfl_mode_e m);
    return (m == MODE_DOUT || m == MODE_DIO) ? 6'd16 : 6'd32;
  endfunction

  function automatic logic rx_dual(sfl_mode_e m);
    return (m == MODE_DOUT || m == MODE_DIO);
  endfunction

  function automatic logic tx_dual(sfl_mode_e m);
    return (m == MODE_DIO);
  endfunction

  function automatic logic [23:0] byte_addr(logic [WADDR_W-1:0] w);
    return {4'b0000, w, 2'b00};
  endfunction

  // each bit twice, so a two-bit shifter can send a one-line byte
  function automatic logic [15:0] dup8(logic [7:0] b);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i]   = b[i];
      r[2*i+1] = b[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] bswap32(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter sfl_mode_e MODE      = MODE_DIO,
  parameter int        RECOV_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  output logic cs_n,
  output logic sck,
  output logic busy,
  output logic load_wake,
  output logic load_frame,
  output logic tx_shift,
  output logic rx_cap,
  output logic rx_last,
  output logic wake_ph,
  output logic send_ph,
  output logic recv_ph,
  output logic cmd_ph
);

  localparam logic [CNT_W-1:0] SEND_N  = send_clks(MODE);
  localparam logic [CNT_W-1:0] RECV_N  = recv_clks(MODE);
  localparam logic [CNT_W-1:0] CMD_LIM = SEND_N - CMD_CLKS;
  localparam int               RC_W    = $clog2(RECOV_CYC + 1);

  sfl_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  rcnt;
  logic             cs_q, sck_q;
  logic             active;

  assign active     = (state == ST_WAKE) || (state == ST_SEND) || (state == ST_RECV);
  assign busy       = (state != ST_IDLE);
  assign cs_n       = cs_q;
  assign sck        = sck_q;
  assign load_wake  = (state == ST_BOOT);
  assign load_frame = (state == ST_IDLE) && rd_req;
  assign tx_shift   = ((state == ST_WAKE) || (state == ST_SEND)) && sck_q;
  assign rx_cap     = (state == ST_RECV) && sck_q;
  assign rx_last    = rx_cap && (cnt == 6'd1);
  assign wake_ph    = (state == ST_WAKE);
  assign send_ph    = (state == ST_SEND);
  assign recv_ph    = (state == ST_RECV);
  assign cmd_ph     = (state == ST_SEND) && (cnt > CMD_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_BOOT;
      cnt   <= '0;
      rcnt  <= '0;
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      case (state)
        ST_BOOT: begin
          state <= ST_WAKE;
          cs_q  <= 1'b0;
          cnt   <= CMD_CLKS;
        end
        ST_WAKE, ST_SEND, ST_RECV: begin
          sck_q <= ~sck_q;
          if (sck_q) begin
            if (cnt == 6'd1) begin
              if (state == ST_WAKE) begin
                state <= ST_RECOV;
                cs_q  <= 1'b1;
                rcnt  <= RC_W'(RECOV_CYC);
              end else if (state == ST_SEND) begin
                state <= ST_RECV;
                cnt   <= RECV_N;
              end else begin
                state <= ST_IDLE;
                cs_q  <= 1'b1;
              end
            end else begin
              cnt <= cnt - 6'd1;
            end
          end
        end
        ST_RECOV: begin
          if (rcnt <= RC_W'(1)) state <= ST_IDLE;
          else                  rcnt  <= rcnt - RC_W'(1);
        end
        ST_IDLE: begin
          if (rd_req) begin
            state <= ST_SEND;
            cs_q  <= 1'b0;
            cnt   <= SEND_N;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> busy) else $error("chip select active while not busy");

  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sck_q) else $error("serial clock high with chip select inactive");

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_req && !sck_q) |=> $stable(cnt))
    else $error("request while busy disturbed the frame");

  p_recov_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV) |-> (cs_q && busy && active == 1'b0))
    else $error("recovery wait left chip select or busy wrong");

endmodule

// File: rtl/sfl_txsh.sv
module sfl_txsh
  import sfl_pkg::*;
#(
  parameter sfl_mode_e MODE = MODE_DIO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_wake,
  input  logic               load_frame,
  input  logic [WADDR_W-1:0] word_addr,
  input  logic               shift_en,
  input  logic               dual_now,
  output logic [1:0]         top2
);

  logic [FRAME_W-1:0] sh, frame;

  generate
    if (tx_dual(MODE)) begin : g_dual
      assign frame = {dup8(op_of(MODE)), byte_addr(word_addr)};
    end else begin : g_single
      assign frame = {op_of(MODE), byte_addr(word_addr), 8'h00};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh <= '0;
    else if (load_wake)  sh <= {OP_RELEASE, {(FRAME_W-8){1'b0}}};
    else if (load_frame) sh <= frame;
    else if (shift_en)   sh <= dual_now ? {sh[FRAME_W-3:0], 2'b00}
                                        : {sh[FRAME_W-2:0], 1'b0};
  end

  assign top2 = sh[FRAME_W-1:FRAME_W-2];

  p_frame_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_frame && !load_wake) |=> (top2[1] == op_of(MODE)[7]))
    else $error("opcode MSB not at the head of the frame");

endmodule

// File: rtl/sfl_rxsh.sv
module sfl_rxsh
  import sfl_pkg::*;
#(
  parameter sfl_mode_e MODE = MODE_DIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic [1:0]        io_i,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] rx, rx_nxt;

  generate
    if (rx_dual(MODE)) begin : g_dual
      assign rx_nxt = {rx[WORD_W-3:0], io_i[1], io_i[0]};
    end else begin : g_single
      assign rx_nxt = {rx[WORD_W-2:0], io_i[1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx      <= '0;
      rd_data <= '0;
    end else begin
      if (cap_en)   rx      <= rx_nxt;
      if (cap_last) rd_data <= bswap32(rx_nxt);
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_last |=> $stable(rd_data)) else $error("output word moved between reads");

endmodule

// File: rtl/sflash_rd_port.sv
module sflash_rd_port
  import sfl_pkg::*;
#(
  parameter sfl_mode_e MODE      = MODE_DIO,
  parameter int        RECOV_CYC = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [sfl_pkg::WADDR_W-1:0] rd_word_addr,
  output logic [sfl_pkg::WORD_W-1:0]  rd_data,
  output logic                       rd_busy,
  output logic                       sck,
  output logic                       cs_n,
  output logic [1:0]                 io_o,
  output logic [1:0]                 io_oe,
  input  logic [1:0]                 io_i
);

  localparam logic TX_DUAL = tx_dual(MODE);
  localparam logic RX_DUAL = rx_dual(MODE);

  logic load_wake, load_frame, tx_shift, rx_cap, rx_last;
  logic wake_ph, send_ph, recv_ph, cmd_ph, dual_now;
  logic [1:0] top2;

  sfl_ctrl #(.MODE(MODE), .RECOV_CYC(RECOV_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .cs_n(cs_n), .sck(sck), .busy(rd_busy),
    .load_wake(load_wake), .load_frame(load_frame),
    .tx_shift(tx_shift), .rx_cap(rx_cap), .rx_last(rx_last),
    .wake_ph(wake_ph), .send_ph(send_ph), .recv_ph(recv_ph), .cmd_ph(cmd_ph)
  );

  assign dual_now = send_ph && TX_DUAL;

  sfl_txsh #(.MODE(MODE)) u_txsh (
    .clk(clk), .rst_n(rst_n), .load_wake(load_wake), .load_frame(load_frame),
    .word_addr(rd_word_addr), .shift_en(tx_shift), .dual_now(dual_now),
    .top2(top2)
  );

  sfl_rxsh #(.MODE(MODE)) u_rxsh (
    .clk(clk), .rst_n(rst_n), .cap_en(rx_cap), .cap_last(rx_last),
    .io_i(io_i), .rd_data(rd_data)
  );

  always_comb begin
    io_oe = 2'b01;
    io_o  = 2'b00;
    if (wake_ph) begin
      io_o = {1'b0, top2[1]};
    end else if (send_ph) begin
      if (TX_DUAL && !cmd_ph) begin
        io_oe = 2'b11;
        io_o  = top2;
      end else begin
        io_o = {1'b0, top2[1]};
      end
    end else if (recv_ph) begin
      io_oe = RX_DUAL ? 2'b00 : 2'b01;
    end
  end

  p_io_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(io_o) && $stable(io_oe)))
    else $error("data lines moved across a rising serial clock");

  p_io1_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (io_oe == 2'b01)) else $error("frame must open with IO0 only");

endmodule

// File: tb/sfl_flash_model.sv
module sfl_flash_model #(
  parameter int MODE = 3
) (
  input  logic       sck,
  input  logic       cs_n,
  input  logic [1:0] io_o,
  input  logic [1:0] io_oe,
  output logic [1:0] io_i,
  output int         frames,
  output int         last_rises,
  output int         oe_err,
  output logic [31:0] last_cap
);

  int          k;
  logic [31:0] cap;
  bit          awake;
  bit          seen_low;
  int          s_n, r_n;

  function automatic logic [7:0] fb(logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ {a[21:16], 2'b01};
  endfunction

  initial begin
    io_i = 2'b00; frames = 0; last_rises = 0; oe_err = 0; last_cap = '0;
    k = 0; cap = '0; awake = 0; seen_low = 0;
    s_n = (MODE == 0) ? 32 : (MODE == 3) ? 28 : 40;
    r_n = (MODE >= 2) ? 16 : 32;
  end

  always @(negedge cs_n) begin
    k = 0; cap = '0; seen_low = 1;
  end

  always @(posedge sck) begin
    logic [1:0] exp_oe;
    k = k + 1;
    if (frames == 0)      exp_oe = 2'b01;
    else if (k > s_n)     exp_oe = (MODE >= 2) ? 2'b00 : 2'b01;
    else if (MODE == 3 && k > 8) exp_oe = 2'b11;
    else                  exp_oe = 2'b01;
    if (io_oe !== exp_oe) oe_err = oe_err + 1;
    if (frames == 0 || MODE != 3) begin
      if (k <= 32) cap = {cap[30:0], io_o[0]};
    end else begin
      if (k <= 8)       cap = {cap[30:0], io_o[0]};
      else if (k <= 20) cap = {cap[29:0], io_o[1], io_o[0]};
    end
  end

  always @(negedge sck) begin
    logic [31:0] st;
    int j;
    if (awake && frames > 0 && k >= s_n && k < s_n + r_n) begin
      st = {fb(cap[23:0]), fb(cap[23:0] + 24'd1), fb(cap[23:0] + 24'd2), fb(cap[23:0] + 24'd3)};
      j = k - s_n;
      if (MODE >= 2) io_i = {st[31-2*j], st[30-2*j]};
      else           io_i = {st[31-j], 1'b0};
    end
  end

  always @(posedge cs_n) begin
    if (seen_low) begin
      frames     = frames + 1;
      last_rises = k;
      last_cap   = cap;
      if (!awake && k == 8 && cap[7:0] == 8'hAB) awake = 1;
    end
  end

endmodule

// File: tb/test_sflash_rd_port.sv
`timescale 1ns/1ps
module test_sflash_rd_port;

  localparam int RECOV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [17:0] waddr = '0;

  logic [31:0] rdata [4];
  logic [3:0]  busy, sck_w, csn_w;
  logic [1:0]  io_o [4];
  logic [1:0]  io_oe [4];
  logic [1:0]  io_i [4];
  int          frames [4];
  int          rises [4];
  int          oe_err [4];
  logic [31:0] capw [4];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_m
    sflash_rd_port #(.MODE(sfl_pkg::sfl_mode_e'(m)), .RECOV_CYC(RECOV)) i_sflash_rd_port (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_word_addr(waddr),
      .rd_data(rdata[m]), .rd_busy(busy[m]), .sck(sck_w[m]), .cs_n(csn_w[m]),
      .io_o(io_o[m]), .io_oe(io_oe[m]), .io_i(io_i[m])
    );
    sfl_flash_model #(.MODE(m)) u_flash (
      .sck(sck_w[m]), .cs_n(csn_w[m]), .io_o(io_o[m]), .io_oe(io_oe[m]),
      .io_i(io_i[m]), .frames(frames[m]), .last_rises(rises[m]),
      .oe_err(oe_err[m]), .last_cap(capw[m])
    );
  end

  function automatic logic [7:0] opc(int m);
    case (m)
      0: return 8'h03;
      1: return 8'h0B;
      2: return 8'h3B;
      default: return 8'hBB;
    endcase
  endfunction

  function automatic int nclk(int m);
    case (m)
      0: return 64;
      1: return 72;
      2: return 56;
      default: return 44;
    endcase
  endfunction

  function automatic logic [7:0] byte_at(logic [23:0] a);
    logic [7:0] lo;
    lo = a[7:0] * 8'd29;
    return lo ^ a[15:8] ^ {a[21:16], 2'b01};
  endfunction

  function automatic logic [31:0] exp_word(logic [17:0] w);
    logic [23:0] a;
    a = {4'b0000, w, 2'b00};
    return {byte_at(a + 24'd3), byte_at(a + 24'd2), byte_at(a + 24'd1), byte_at(a)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [17:0] w);
    @(negedge clk);
    waddr  = w;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // counts busy cycles per instance until all are idle
  task automatic wait_idle(output int cyc [4]);
    for (int m = 0; m < 4; m++) cyc[m] = 0;
    for (int t = 0; t < 2000; t++) begin
      for (int m = 0; m < 4; m++) if (busy[m]) cyc[m]++;
      if (busy == 4'b0000) return;
      @(negedge clk);
    end
    chk(0, "watchdog-idle", 32'(busy), 32'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(csn_w == 4'hF, "R9 cs_n idle in reset", 32'(csn_w), 32'hF);
    chk(sck_w == 4'h0, "R8 sck low in reset", 32'(sck_w), 32'h0);
    chk(busy == 4'hF, "R1 busy during reset", 32'(busy), 32'hF);
    chk(rdata[0] == 32'h0, "R11 output cleared", rdata[0], 32'h0);
  endtask

  task automatic t_wakeup;
    int rc;
    bit rose_seen;
    rc = 0; rose_seen = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 1000; t++) begin
      @(negedge clk);
      if (t == 4) begin waddr = 18'h00111; rd_req = 1'b1; end   // R10 stray request in release frame
      if (t == 5) rd_req = 1'b0;
      if (!csn_w[0]) rose_seen = 1;
      if (rose_seen && csn_w[0] && busy[0]) rc++;
      if (rose_seen && !busy[0]) break;
    end
    chk(rc == RECOV, "R2 recovery length", 32'(rc), 32'(RECOV));
    for (int m = 0; m < 4; m++) begin
      chk(frames[m] == 1, "R1 release frame count", 32'(frames[m]), 32'd1);
      chk(rises[m] == 8, "R1 release frame clocks", 32'(rises[m]), 32'd8);
      chk(capw[m][7:0] == 8'hAB, "R1 release opcode", 32'(capw[m][7:0]), 32'hAB);
    end
    repeat (5) @(negedge clk);
    chk(frames[3] == 1 && busy == 4'h0, "R10 stray request ignored", 32'(frames[3]), 32'd1);
  endtask

  task automatic t_read(input logic [17:0] w);
    int f0 [4];
    int cyc [4];
    for (int m = 0; m < 4; m++) f0[m] = frames[m];
    pulse_req(w);
    wait_idle(cyc);
    for (int m = 0; m < 4; m++) begin
      chk(rdata[m] == exp_word(w), "R7 word value", rdata[m], exp_word(w));
      chk(capw[m][31:24] == opc(m), "R3 opcode", 32'(capw[m][31:24]), 32'(opc(m)));
      chk(capw[m][23:0] == {4'b0000, w, 2'b00}, "R4 address", 32'(capw[m][23:0]), 32'({4'b0000, w, 2'b00}));
      chk(rises[m] == nclk(m), "R5 serial clocks", 32'(rises[m]), 32'(nclk(m)));
      chk(cyc[m] == 2 * nclk(m), "R5 busy length", 32'(cyc[m]), 32'(2 * nclk(m)));
      chk(frames[m] == f0[m] + 1, "R5 one frame", 32'(frames[m]), 32'(f0[m] + 1));
    end
  endtask

  task automatic t_ignore(input logic [17:0] w1, input logic [17:0] w2);
    int f0 [4];
    int cyc [4];
    for (int m = 0; m < 4; m++) f0[m] = frames[m];
    pulse_req(w1);
    repeat (10) @(negedge clk);
    waddr = w2; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_idle(cyc);
    repeat (4) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk(rdata[m] == exp_word(w1), "R10 word from first request", rdata[m], exp_word(w1));
      chk(frames[m] == f0[m] + 1, "R10 no extra frame", 32'(frames[m]), 32'(f0[m] + 1));
    end
  endtask

  task automatic t_hold;
    logic [31:0] keep [4];
    int f0 [4];
    for (int m = 0; m < 4; m++) begin keep[m] = rdata[m]; f0[m] = frames[m]; end
    waddr = 18'h2F0F0;
    repeat (30) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk(rdata[m] == keep[m], "R11 word held", rdata[m], keep[m]);
      chk(frames[m] == f0[m], "R11 no frame without request", 32'(frames[m]), 32'(f0[m]));
    end
    chk(sck_w == 4'h0 && csn_w == 4'hF, "R8 sck parked low", 32'(sck_w), 32'h0);
  endtask

  task automatic t_dirs;
    for (int m = 0; m < 4; m++)
      chk(oe_err[m] == 0, "R6 line direction errors", 32'(oe_err[m]), 32'h0);
  endtask

  initial begin
    t_reset;
    t_wakeup;
    t_read(18'h00000);
    t_read(18'h3FFFF);
    t_read(18'h12345);
    t_read(18'h2AAAA);
    t_ignore(18'h01234, 18'h3C3C3);
    t_hold;
    t_read(18'h15555);
    t_dirs;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule